// File: doc/BRIEF.md
# Frame-Synchronized Serial Sample Receiver

This block receives 16-bit two's complement samples from a converter that generates its own serial bit clock. The converter pulls its active-low frame line down for the whole of each transfer. It sends the bits most significant first, and it holds the data and bit clock lines low whenever no transfer is running. The receiver synchronizes all three lines into the system clock domain and detects edges on them. It shifts in one bit per qualified bit-clock edge and checks the bit count when the frame closes.

Each word that arrives during one conversion holds the result of the conversion before it. The receiver therefore counts frames from reset and tags each word with the index of the previous frame. The first frame after reset has no earlier result. It is reported as such and never produces a word. A frame that closes with a bit count other than 16 raises an error pulse, and its bits are discarded.

A complete word appears on a parallel output for one cycle, marked by a valid strobe. The word comes with a copy sign-extended to 32 bits. A parameter selects whether bits are captured on the rising or the falling bit-clock edge, because the converter holds each bit valid across both.

Top module: `frame_sample_rx`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is zero.
- R2: A frame is the interval in which the synchronized `frameN` is low. Bit-clock edges while `frameN` is high change no state, so the next frame's word is unaffected. Each input level must last at least three system clock cycles.
- R3: Bits are captured on rising edges of `bitClk`. The first captured bit becomes bit 15 of `wordData`, and each later bit moves one position toward bit 0.
- R4: Let `frameN` be first sampled high at clock edge k. The resulting `wordValid`, `frameErr` or `noPrior` pulse is high from edge k+2 to edge k+3, and only for that one cycle.
- R5: `wordData` changes only when `wordValid` is high. `wordSext` equals `wordData` with bit 15 copied into bits 31..16.
- R6: Frames are numbered from 0 after reset, modulo 256, and every frame advances the number, including errored frames. A word carries in `wordTag` the number of the frame before the one that delivered it.
- R7: The first frame after reset pulses `noPrior` and never pulses `wordValid`.
- R8: A frame that closes with a count other than 16 rising bit-clock edges pulses `frameErr` and does not pulse `wordValid`. This covers a frame with no edges. `wordData` keeps its previous value.
- R9: A reset that arrives in the middle of a frame drops that frame. The frame in progress when reset is released counts as the first frame after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Converter busy line, low during a transfer |
| bitClk | input | 1 | Serial bit clock driven by the converter |
| serData | input | 1 | Serial data, MSB first |
| wordValid | output | 1 | One-cycle strobe for a complete word |
| wordData | output | 16 | Received word, two's complement |
| wordSext | output | 32 | Received word sign-extended |
| wordTag | output | 8 | Index of the conversion the word belongs to |
| frameErr | output | 1 | One-cycle pulse for a frame with a wrong bit count |
| noPrior | output | 1 | One-cycle pulse closing the first frame after reset |

## Verification
The words sent are 0x8000, 0x7FFF, 0xA5C3, 0x0001, 0xFFFF, 0x00FF and 0xFF00. Together they separate a correct bit order from a reversed one and a correct sign copy from a zero fill, and they show shifts of one place at either end of the word. Frames of 15, 17 and zero bits exercise the length check on both sides of 16. Bit-clock pulses driven while the frame line is high show whether stray edges leak into the next word. A reset in the middle of a frame, with the frame then finished, shows that the index restarts and that the first-frame rule applies again. Every cycle is also compared against a behavioural model, which exposes a wrong pulse latency or a pulse that lasts too long.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic clearAll;  // frame opened: empty the shift register
    logic shiftEn;   // accept one serial bit
    logic loadOut;   // publish the assembled word
  } fsrStrobe_t;

endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[i] <= RST_VAL[i];
        stage2[i] <= RST_VAL[i];
      end else begin
        stage1[i] <= din[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign dout = stage2;

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int IDX_W        = 8,
  parameter bit CAPTURE_FALL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameLvl,   // synchronized busy line
  input  logic             bclkLvl,    // synchronized bit clock
  output fsrStrobe_t       strobes,
  output logic [IDX_W-1:0] tagOut,
  output logic             errPulse,
  output logic             primePulse
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic             frameQ;
  logic             bclkQ;
  logic [CNT_W-1:0] bitCnt;
  logic             seenQ;
  logic [IDX_W-1:0] convIdx;

  logic frameEndC;
  logic frameStartC;
  logic bclkRiseC;
  logic bclkFallC;
  logic bitEdgeC;
  logic bitTakeC;
  logic lenOkC;

  // edge detection on the synchronized lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= 1'b1;
      bclkQ  <= 1'b0;
    end else begin
      frameQ <= frameLvl;
      bclkQ  <= bclkLvl;
    end
  end

  assign frameEndC   = frameLvl & ~frameQ;
  assign frameStartC = ~frameLvl & frameQ;
  assign bclkRiseC   = bclkLvl & ~bclkQ;
  assign bclkFallC   = ~bclkLvl & bclkQ;
  assign bitEdgeC    = CAPTURE_FALL ? bclkFallC : bclkRiseC;
  assign bitTakeC    = bitEdgeC & ~frameLvl & ~frameStartC;
  assign lenOkC      = (bitCnt == CNT_FULL);

  // bit counter, saturating one past a full word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (frameStartC) begin
      bitCnt <= '0;
    end else if (bitTakeC && (bitCnt != CNT_SAT)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // conversion index and first-frame tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenQ   <= 1'b0;
      convIdx <= '0;
    end else if (frameEndC) begin
      seenQ   <= 1'b1;
      convIdx <= convIdx + 1'b1;
    end
  end

  // the word in flight belongs to the previous conversion
  assign tagOut = convIdx - IDX_W'(1);

  always_comb begin
    strobes          = '0;
    strobes.clearAll = frameStartC;
    strobes.shiftEn  = bitTakeC & (bitCnt < CNT_FULL);
    strobes.loadOut  = frameEndC & lenOkC & seenQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPulse   <= 1'b0;
      primePulse <= 1'b0;
    end else begin
      errPulse   <= frameEndC & ~lenOkC;
      primePulse <= frameEndC & ~seenQ;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_SAT); // R8

  AST_FIRST_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !seenQ |-> !strobes.loadOut); // R7

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameEndC) |-> convIdx == $past(convIdx) + 1'b1); // R6

endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsrStrobe_t        strobes,
  input  logic              dataLvl,
  input  logic [IDX_W-1:0]  tagIn,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic [EXT_W-1:0]  wordSext,
  output logic [IDX_W-1:0]  wordTag
);

  localparam int PAD_W = EXT_W - WORD_W;

  logic [WORD_W-1:0] shiftQ;
  logic [EXT_W-1:0]  extC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (strobes.clearAll) begin
      shiftQ <= '0;
    end else if (strobes.shiftEn) begin
      shiftQ <= {shiftQ[WORD_W-2:0], dataLvl};
    end
  end

  if (PAD_W > 0) begin : g_pad
    assign extC = {{PAD_W{shiftQ[WORD_W-1]}}, shiftQ};
  end else begin : g_nopad
    assign extC = shiftQ[EXT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordData  <= '0;
      wordSext  <= '0;
      wordTag   <= '0;
    end else begin
      wordValid <= strobes.loadOut;
      if (strobes.loadOut) begin
        wordData <= shiftQ;
        wordSext <= extC;
        wordTag  <= tagIn;
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid); // R4

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(wordData)); // R5

endmodule

// File: rtl/frame_sample_rx.sv
module frame_sample_rx
  import fsr_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int EXT_W        = 32,
  parameter int IDX_W        = 8,
  parameter bit CAPTURE_FALL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              bitClk,
  input  logic              serData,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic [EXT_W-1:0]  wordSext,
  output logic [IDX_W-1:0]  wordTag,
  output logic              frameErr,
  output logic              noPrior
);

  logic [1:0]       ctlLvl;   // {bit clock, frame}
  logic             dataLvl;
  fsrStrobe_t       strobes;
  logic [IDX_W-1:0] tagC;

  fsr_sync #(.W(2), .RST_VAL(2'b01)) u_ctlSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({bitClk, frameN}),
    .dout (ctlLvl)
  );

  fsr_sync #(.W(1), .RST_VAL(1'b0)) u_dataSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (serData),
    .dout (dataLvl)
  );

  fsr_ctrl #(
    .WORD_W       (WORD_W),
    .IDX_W        (IDX_W),
    .CAPTURE_FALL (CAPTURE_FALL)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameLvl   (ctlLvl[0]),
    .bclkLvl    (ctlLvl[1]),
    .strobes    (strobes),
    .tagOut     (tagC),
    .errPulse   (frameErr),
    .primePulse (noPrior)
  );

  fsr_datapath #(
    .WORD_W (WORD_W),
    .EXT_W  (EXT_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dataLvl   (dataLvl),
    .tagIn     (tagC),
    .wordValid (wordValid),
    .wordData  (wordData),
    .wordSext  (wordSext),
    .wordTag   (wordTag)
  );

endmodule

// File: tb/frame_sample_rx_tb_top.sv
module frame_sample_rx_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1;
  logic bitClk = 1'b0;
  logic serData = 1'b0;

  logic        wordValid;
  logic [15:0] wordData;
  logic [31:0] wordSext;
  logic [7:0]  wordTag;
  logic        frameErr;
  logic        noPrior;

  int vecCount = 0;
  int missCount = 0;
  bit running = 1'b0;

  always #2.5 clk = ~clk;

  frame_sample_rx dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameN    (frameN),
    .bitClk    (bitClk),
    .serData   (serData),
    .wordValid (wordValid),
    .wordData  (wordData),
    .wordSext  (wordSext),
    .wordTag   (wordTag),
    .frameErr  (frameErr),
    .noPrior   (noPrior)
  );

  // ---------------- behavioural reference model ----------------
  // history of inputs seen at past clock edges: {data, bitclk, frame}
  logic [2:0] hist [$];
  int   mCnt;
  int   mShift;
  bit   mSeen;
  int   mIdx;
  bit   eValid, eErr, ePrime;
  int   eData, eTag;

  initial begin
    for (int i = 0; i < 4; i++) hist.push_back(3'b001);
    mCnt = 0; mShift = 0; mSeen = 0; mIdx = 0;
    eValid = 0; eErr = 0; ePrime = 0; eData = 0; eTag = 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      hist.delete();
      for (int i = 0; i < 4; i++) hist.push_back(3'b001);
      mCnt = 0; mShift = 0; mSeen = 0; mIdx = 0;
      eValid = 0; eErr = 0; ePrime = 0; eData = 0; eTag = 0;
    end else begin
      logic [2:0] cur, old;
      hist.push_front({serData, bitClk, frameN});
      void'(hist.pop_back());
      cur = hist[2];   // as seen two edges ago
      old = hist[3];
      eValid = 0; eErr = 0; ePrime = 0;
      if (cur[0] && !old[0]) begin
        if (mCnt != 16) eErr = 1;
        if (!mSeen) ePrime = 1;
        if (mCnt == 16 && mSeen) begin
          eValid = 1;
          eData  = mShift;
          eTag   = (mIdx + 255) % 256;
        end
        mIdx  = (mIdx + 1) % 256;
        mSeen = 1;
      end
      if (!cur[0] && old[0]) begin
        mCnt = 0;
        mShift = 0;
      end else if (cur[1] && !old[1] && !cur[0]) begin
        if (mCnt < 16) mShift = ((mShift << 1) | int'(cur[2])) & 16'hFFFF;
        if (mCnt < 17) mCnt++;
      end
    end
  end

  function automatic void cmp(input string req, input string what,
                              input longint act, input longint exp);
    vecCount++;
    if (act != exp) begin
      missCount++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (running) begin
      if (!rstN) begin
        cmp("R1", "reset outputs", {wordValid, wordData, wordSext, wordTag, frameErr, noPrior}, 0);
      end else begin
        longint expSext;
        expSext = eData[15] ? (longint'(eData) | 64'hFFFF0000) : longint'(eData);
        cmp("R4", "wordValid", wordValid, eValid);
        cmp("R3", "wordData", wordData, eData);
        cmp("R5", "wordSext", wordSext, expSext);
        cmp("R6", "wordTag", wordTag, eTag);
        cmp("R8", "frameErr", frameErr, eErr);
        cmp("R7", "noPrior", noPrior, ePrime);
      end
    end
  end

  // ---------------- stimulus ----------------
  bit          gotValid, gotErr, gotPrime;
  logic [15:0] lastWord;
  logic [31:0] lastSext;
  logic [7:0]  lastTag;
  int          latency;

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic sendFrame(input logic [31:0] bits, input int n, input int rstAt);
    step(1);
    frameN = 1'b0;
    step(4);
    for (int i = 0; i < n; i++) begin
      if (i == rstAt) begin
        rstN = 1'b0;
        step(3);
        rstN = 1'b1;
        step(3);
      end
      serData = bits[n-1-i];
      step(3);
      bitClk = 1'b1;
      step(3);
      bitClk = 1'b0;
    end
    serData = 1'b0;
    step(3);
    frameN = 1'b1;
    gotValid = 0; gotErr = 0; gotPrime = 0; latency = -1;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if ((wordValid || frameErr || noPrior) && latency < 0) latency = j;
      if (wordValid) begin
        gotValid = 1;
        lastWord = wordData;
        lastSext = wordSext;
        lastTag  = wordTag;
      end
      if (frameErr) gotErr = 1;
      if (noPrior) gotPrime = 1;
    end
  endtask

  task automatic strayClocks(input int n);
    serData = 1'b1;
    for (int i = 0; i < n; i++) begin
      step(3);
      bitClk = 1'b1;
      step(3);
      bitClk = 1'b0;
    end
    serData = 1'b0;
    step(4);
  endtask

  task automatic expectWord(input string req, input logic [15:0] w,
                            input logic [31:0] s, input logic [7:0] t);
    cmp(req, "word delivered", gotValid, 1);
    cmp(req, "word value", lastWord, w);
    cmp(req, "sign-extended value", lastSext, s);
    cmp(req, "conversion tag", lastTag, t);
    cmp("R4", "pulse latency", latency, 4);
  endtask

  task automatic expectNoWord(input string req, input bit err, input bit prime);
    cmp(req, "no word delivered", gotValid, 0);
    cmp(req, "error pulse", gotErr, err);
    cmp(req, "first-frame pulse", gotPrime, prime);
  endtask

  initial begin
    running = 1'b1;
    step(6);
    rstN = 1'b1;
    step(3);

    sendFrame(32'h1234, 16, -1);           // first frame: R7
    expectNoWord("R7", 0, 1);
    sendFrame(32'h8000, 16, -1);           // MSB alone: R3, sign fill: R5
    expectWord("R3", 16'h8000, 32'hFFFF8000, 8'd0);
    sendFrame(32'h7FFF, 16, -1);
    expectWord("R5", 16'h7FFF, 32'h00007FFF, 8'd1);
    strayClocks(5);                        // edges outside a frame: R2
    sendFrame(32'hA5C3, 16, -1);
    expectWord("R2", 16'hA5C3, 32'hFFFFA5C3, 8'd2);
    sendFrame(32'h7FFF, 15, -1);           // short frame: R8
    expectNoWord("R8", 1, 0);
    cmp("R8", "word held after error", wordData, 16'hA5C3);
    sendFrame(32'h0001, 16, -1);           // index advanced over error: R6
    expectWord("R6", 16'h0001, 32'h00000001, 8'd4);
    sendFrame(32'h1FFFF, 17, -1);          // long frame: R8
    expectNoWord("R8", 1, 0);
    sendFrame(32'h0, 0, -1);               // empty frame: R8
    expectNoWord("R8", 1, 0);
    sendFrame(32'hFFFF, 16, -1);
    expectWord("R5", 16'hFFFF, 32'hFFFFFFFF, 8'd7);
    sendFrame(32'h5555, 16, 6);            // reset mid-frame: R9
    expectNoWord("R9", 1, 1);
    sendFrame(32'h00FF, 16, -1);
    expectWord("R9", 16'h00FF, 32'h000000FF, 8'd0);
    sendFrame(32'hFF00, 16, -1);
    expectWord("R6", 16'hFF00, 32'hFFFFFF00, 8'd1);

    step(5);
    running = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule